// File: doc/BRIEF.md
# Flash program/erase control interlock

This block guards an on-chip flash array. It sits between the CPU and the array and holds four control bits. A latch-arm bit (`latch_en`) turns on address and data capture for programming. An erase-select bit (`erase_sel`) chooses between programming and erasing. A boot-lock bit (`boot_lock`) is stored for use by neighbouring logic. A commit bit (`pe_en`) applies high voltage. Each bit can move only in a safe order. Arming requires an elevated programming-voltage indication. Committing requires that a word was captured after arming. Once the commit bit is set, the other bits are frozen.

The block also steers array reads. A normal read returns the addressed word. A read while armed for programming returns the word at the captured address. A read while high voltage is applied is ignored: the data bus shows all ones and a status flag is raised. When the commit bit rises, the block issues a one-cycle program pulse or erase pulse to the array.

Top module: `flash_pe_interlock`

## Requirements
- R1: Control register bit 0 is `latch_en`, bit 1 is `erase_sel`, bit 2 is `boot_lock` and bit 3 is `pe_en`. `reg_rdata` always shows them. When `pe_en` is clear, a register write loads bits 1 and 2 as written. It sets `latch_en` only if `vpp_high` is 1 in that cycle; otherwise `latch_en` becomes 0.
- R2: A write with bit 3 set makes `pe_en` 1 only if three things hold: `latch_en` was already 1 before the write, a word was captured in an earlier cycle, and the write keeps bit 0 set. Otherwise `pe_en` stays 0. An array write in the same cycle as the register write does not count as the earlier capture.
- R3: While `pe_en` is 1, a register write cannot change bits 0 to 2; it can only clear `pe_en`.
- R4: A write that sets bit 3 and clears bit 0 in the same access leaves `pe_en` at 0 and produces no program or erase pulse.
- R5: With `pe_en`=0 and `latch_en`=0, a read returns the word at `arr_addr`.
- R6: With `pe_en`=0, `latch_en`=1 and `erase_sel`=0, a read returns the array word at the captured address, whatever `arr_addr` is.
- R7: With `pe_en`=0, `latch_en`=1 and `erase_sel`=1, a read returns the word at `arr_addr`.
- R8: While `pe_en`=1, a read returns all ones and raises `rd_ignored` in that cycle. The control register stays readable.
- R9: `latches_loaded` clears whenever `latch_en` changes. The first array write while `latch_en`=1 and `pe_en`=0 captures the address and data and sets the flag. Later array writes, and array writes while `latch_en`=0, change nothing.
- R10: `hv_enable` equals `pe_en`. In the cycle `pe_en` rises, exactly one pulse appears: `mem_prog` (captured data to captured address) if `erase_sel`=0, or `mem_erase` if `erase_sel`=1.
- R11: Reset clears all control bits, the capture flag and both pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 4 | Control register write value |
| reg_rdata | output | 4 | Control register contents |
| vpp_high | input | 1 | Programming voltage detected as elevated |
| arr_rd | input | 1 | CPU array read strobe |
| arr_wr | input | 1 | CPU array write strobe (loads capture latches) |
| arr_addr | input | AW | CPU array address |
| arr_wdata | input | DW | CPU array write data |
| arr_rdata | output | DW | Data returned to the CPU |
| rd_ignored | output | 1 | Read was ignored because high voltage is on |
| latches_loaded | output | 1 | A word has been captured since arming |
| mem_addr | output | AW | Address presented to the array |
| mem_wdata | output | DW | Captured word presented to the array |
| mem_rdata | input | DW | Array read data |
| mem_prog | output | 1 | One-cycle program pulse |
| mem_erase | output | 1 | One-cycle erase pulse |
| hv_enable | output | 1 | High-voltage enable to the array |

## Verification
Two events can fall in the same clock: a register write that asks for `pe_en`, and an array write that loads the capture latches. The bench issues both in one cycle. It expects `pe_en` to stay 0 while `latches_loaded` becomes 1, and a repeat of the register write alone then succeeds. A second collision clears the arm bit together with a commit request. It is judged by `pe_en` staying 0, the capture flag clearing and no program pulse reaching the model array.

// File: rtl/fpe_pkg.sv
package fpe_pkg;

  localparam int CTRL_W = 4;

  typedef struct packed {
    logic pe;
    logic boot;
    logic eras;
    logic lat;
  } fpe_ctrl_t;

  // Next control state for one register write.
  function automatic fpe_ctrl_t fpe_next_ctrl(fpe_ctrl_t cur, logic [CTRL_W-1:0] wd,
                                              logic vpp_ok, logic loaded);
    fpe_ctrl_t req;
    fpe_ctrl_t nxt;
    req = fpe_ctrl_t'(wd);
    if (cur.pe) begin
      nxt    = cur;
      nxt.pe = req.pe & cur.lat & loaded;
    end else begin
      nxt.lat  = req.lat & vpp_ok;
      nxt.eras = req.eras;
      nxt.boot = req.boot;
      nxt.pe   = req.pe & nxt.lat & cur.lat & loaded;
    end
    return nxt;
  endfunction

  // Reads go to the captured address while armed for programming.
  function automatic logic fpe_redirect(fpe_ctrl_t c);
    return !c.pe && c.lat && !c.eras;
  endfunction

endpackage

// File: rtl/fpe_ctrl_reg.sv
module fpe_ctrl_reg
  import fpe_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [CTRL_W-1:0] reg_wdata,
  input  logic              vpp_high,
  input  logic              loaded_q,
  output fpe_ctrl_t         ctrl_q,
  output fpe_ctrl_t         ctrl_d,
  output logic              start_prog,
  output logic              start_erase
);

  logic pe_start;

  assign ctrl_d      = reg_wr ? fpe_next_ctrl(ctrl_q, reg_wdata, vpp_high, loaded_q) : ctrl_q;
  assign pe_start    = reg_wr && !ctrl_q.pe && ctrl_d.pe;
  assign start_prog  = pe_start && !ctrl_d.eras;
  assign start_erase = pe_start && ctrl_d.eras;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  p_lat_needs_vpp_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !ctrl_q.pe && !vpp_high) |=> !ctrl_q.lat);

  p_pe_needs_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !ctrl_q.pe && !(ctrl_q.lat && loaded_q)) |=> !ctrl_q.pe);

  p_frozen_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q.pe |=> ($stable(ctrl_q.lat) && $stable(ctrl_q.eras) && $stable(ctrl_q.boot)));

  p_no_start_on_disarm_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !ctrl_q.pe && reg_wdata[3] && !reg_wdata[0]) |=> !ctrl_q.pe);

endmodule

// File: rtl/fpe_latch.sv
module fpe_latch #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lat_q,
  input  logic          lat_d,
  input  logic          pe_q,
  input  logic          arr_wr,
  input  logic [AW-1:0] arr_addr,
  input  logic [DW-1:0] arr_wdata,
  output logic          loaded_q,
  output logic [AW-1:0] lat_addr_q,
  output logic [DW-1:0] lat_data_q,
  output logic          capture
);

  logic lat_edge;

  assign lat_edge = lat_d != lat_q;
  assign capture  = arr_wr && lat_q && !pe_q && !loaded_q && !lat_edge;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loaded_q   <= 1'b0;
      lat_addr_q <= '0;
      lat_data_q <= '0;
    end else if (lat_edge) begin
      loaded_q <= 1'b0;
    end else if (capture) begin
      loaded_q   <= 1'b1;
      lat_addr_q <= arr_addr;
      lat_data_q <= arr_wdata;
    end
  end

  p_clear_on_arm_change_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(lat_q) || $fell(lat_q)) |-> !loaded_q);

  p_capture_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
    loaded_q |=> ($stable(lat_addr_q) && $stable(lat_data_q)));

  p_loaded_needs_arm_r9: assert property (@(posedge clk) disable iff (!rst_n)
    loaded_q |-> lat_q);

endmodule

// File: rtl/fpe_array_port.sv
module fpe_array_port
  import fpe_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  fpe_ctrl_t     ctrl_q,
  input  logic          start_prog,
  input  logic          start_erase,
  input  logic          arr_rd,
  input  logic [AW-1:0] arr_addr,
  input  logic [AW-1:0] lat_addr,
  input  logic [DW-1:0] mem_rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_prog,
  output logic          mem_erase,
  output logic [DW-1:0] arr_rdata,
  output logic          rd_ignored
);

  logic use_latch_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_prog  <= 1'b0;
      mem_erase <= 1'b0;
    end else begin
      mem_prog  <= start_prog;
      mem_erase <= start_erase;
    end
  end

  assign use_latch_addr = mem_prog || fpe_redirect(ctrl_q);
  assign mem_addr       = use_latch_addr ? lat_addr : arr_addr;
  assign arr_rdata      = ctrl_q.pe ? {DW{1'b1}} : mem_rdata;
  assign rd_ignored     = arr_rd && ctrl_q.pe;

  p_pulse_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_prog, mem_erase}));

  p_pulse_with_hv_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_prog || mem_erase) |-> ctrl_q.pe);

  p_pulse_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_prog || mem_erase) |=> !(mem_prog || mem_erase));

  p_redirect_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q.pe && ctrl_q.lat && !ctrl_q.eras) |-> (mem_addr == lat_addr));

  p_ignored_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_rd && ctrl_q.pe) |-> (rd_ignored && (&arr_rdata)));

endmodule

// File: rtl/flash_pe_interlock.sv
module flash_pe_interlock
  import fpe_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [CTRL_W-1:0] reg_wdata,
  output logic [CTRL_W-1:0] reg_rdata,
  input  logic              vpp_high,
  input  logic              arr_rd,
  input  logic              arr_wr,
  input  logic [AW-1:0]     arr_addr,
  input  logic [DW-1:0]     arr_wdata,
  output logic [DW-1:0]     arr_rdata,
  output logic              rd_ignored,
  output logic              latches_loaded,
  output logic [AW-1:0]     mem_addr,
  output logic [DW-1:0]     mem_wdata,
  input  logic [DW-1:0]     mem_rdata,
  output logic              mem_prog,
  output logic              mem_erase,
  output logic              hv_enable
);

  fpe_ctrl_t     ctrl_q;
  fpe_ctrl_t     ctrl_d;
  logic          start_prog;
  logic          start_erase;
  logic          loaded_q;
  logic          capture;
  logic [AW-1:0] lat_addr;
  logic [DW-1:0] lat_data;

  fpe_ctrl_reg u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr      (reg_wr),
    .reg_wdata   (reg_wdata),
    .vpp_high    (vpp_high),
    .loaded_q    (loaded_q),
    .ctrl_q      (ctrl_q),
    .ctrl_d      (ctrl_d),
    .start_prog  (start_prog),
    .start_erase (start_erase)
  );

  fpe_latch #(.AW(AW), .DW(DW)) u_latch (
    .clk        (clk),
    .rst_n      (rst_n),
    .lat_q      (ctrl_q.lat),
    .lat_d      (ctrl_d.lat),
    .pe_q       (ctrl_q.pe),
    .arr_wr     (arr_wr),
    .arr_addr   (arr_addr),
    .arr_wdata  (arr_wdata),
    .loaded_q   (loaded_q),
    .lat_addr_q (lat_addr),
    .lat_data_q (lat_data),
    .capture    (capture)
  );

  fpe_array_port #(.AW(AW), .DW(DW)) u_port (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctrl_q      (ctrl_q),
    .start_prog  (start_prog),
    .start_erase (start_erase),
    .arr_rd      (arr_rd),
    .arr_addr    (arr_addr),
    .lat_addr    (lat_addr),
    .mem_rdata   (mem_rdata),
    .mem_addr    (mem_addr),
    .mem_prog    (mem_prog),
    .mem_erase   (mem_erase),
    .arr_rdata   (arr_rdata),
    .rd_ignored  (rd_ignored)
  );

  assign reg_rdata      = ctrl_q;
  assign latches_loaded = loaded_q;
  assign mem_wdata      = lat_data;
  assign hv_enable      = ctrl_q.pe;

  // A capture and a commit request in the same cycle: the commit must not see it.
  p_same_cycle_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (capture && !ctrl_q.pe) |=> !ctrl_q.pe);

  p_hv_follows_pe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    hv_enable == reg_rdata[3]);

endmodule

// File: tb/flash_pe_interlock_tb.sv
module flash_pe_interlock_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int NW = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr = 1'b0;
  logic [3:0]    reg_wdata = '0;
  logic [3:0]    reg_rdata;
  logic          vpp_high = 1'b0;
  logic          arr_rd = 1'b0;
  logic          arr_wr = 1'b0;
  logic [AW-1:0] arr_addr = '0;
  logic [DW-1:0] arr_wdata = '0;
  logic [DW-1:0] arr_rdata;
  logic          rd_ignored;
  logic          latches_loaded;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata;
  logic          mem_prog;
  logic          mem_erase;
  logic          hv_enable;

  logic [DW-1:0] mem [NW];
  logic [DW-1:0] exp_mem [NW];
  logic          init_req = 1'b1;
  int            prog_cnt = 0;
  int            erase_cnt = 0;
  int            errors = 0;
  int            checks = 0;
  bit            done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_pe_interlock #(.AW(AW), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .vpp_high(vpp_high), .arr_rd(arr_rd), .arr_wr(arr_wr),
    .arr_addr(arr_addr), .arr_wdata(arr_wdata), .arr_rdata(arr_rdata),
    .rd_ignored(rd_ignored), .latches_loaded(latches_loaded), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_prog(mem_prog),
    .mem_erase(mem_erase), .hv_enable(hv_enable)
  );

  function automatic logic [DW-1:0] seed_val(int i);
    return DW'((i * 37 + 11) & 8'hFF);
  endfunction

  // Behavioural array model
  assign mem_rdata = mem[mem_addr];
  always @(posedge clk) begin
    if (init_req) begin
      for (int i = 0; i < NW; i++) mem[i] <= seed_val(i);
    end else if (mem_erase) begin
      for (int i = 0; i < NW; i++) mem[i] <= '1;
    end else if (mem_prog) begin
      mem[mem_addr] <= mem_wdata;
    end
    if (rst_n && mem_prog)  prog_cnt  <= prog_cnt + 1;
    if (rst_n && mem_erase) erase_cnt <= erase_cnt + 1;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic reg_write(logic [3:0] v);
    @(negedge clk); reg_wr = 1'b1; reg_wdata = v;
    @(posedge clk); #1; reg_wr = 1'b0;
  endtask

  task automatic arr_write(logic [AW-1:0] a, logic [DW-1:0] d);
    @(negedge clk); arr_wr = 1'b1; arr_addr = a; arr_wdata = d;
    @(posedge clk); #1; arr_wr = 1'b0;
  endtask

  task automatic both_write(logic [3:0] v, logic [AW-1:0] a, logic [DW-1:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_wdata = v; arr_wr = 1'b1; arr_addr = a; arr_wdata = d;
    @(posedge clk); #1; reg_wr = 1'b0; arr_wr = 1'b0;
  endtask

  task automatic rd_check(string req, logic [AW-1:0] a, logic [DW-1:0] exp, logic exp_ign);
    @(negedge clk); arr_rd = 1'b1; arr_addr = a;
    #1;
    chk(req, 32'(arr_rdata), 32'(exp));
    chk(req, 32'(rd_ignored), 32'(exp_ign));
    arr_rd = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int pc;
    repeat (3) @(posedge clk);
    #1; init_req = 1'b0;
    for (int i = 0; i < NW; i++) exp_mem[i] = seed_val(i);
    @(negedge clk); rst_n = 1'b1;
    #1;
    // R11 reset state
    chk("R11 ctrl", 32'(reg_rdata), 0);
    chk("R11 hv", 32'(hv_enable), 0);
    chk("R11 loaded", 32'(latches_loaded), 0);

    // R5 normal reads over every address
    for (int a = 0; a < NW; a++) rd_check("R5", AW'(a), exp_mem[a], 1'b0);

    // R1 sweep of every write value against both voltage states (R2: commit refused, not armed)
    for (int v = 0; v < 16; v++) begin
      for (int vp = 0; vp < 2; vp++) begin
        @(negedge clk); vpp_high = vp[0];
        reg_write(4'(v));
        chk("R1 sweep", 32'(reg_rdata), 32'({1'b0, v[2], v[1], v[0] & vp[0]}));
        reg_write(4'h0);
      end
    end

    vpp_high = 1'b1;
    reg_write(4'h1);
    chk("R1 armed", 32'(reg_rdata), 32'h1);
    chk("R9 fresh arm", 32'(latches_loaded), 0);
    reg_write(4'h9);
    chk("R2 no capture yet", 32'(reg_rdata), 32'h1);

    // R9 capture, later writes ignored; R6 redirected reads
    arr_write(4'd5, 8'hA5);
    chk("R9 captured", 32'(latches_loaded), 1);
    arr_write(4'd9, 8'h11);
    for (int a = 0; a < NW; a++) rd_check("R6 redirect", AW'(a), exp_mem[5], 1'b0);

    // R4 commit with disarm: nothing happens
    pc = prog_cnt;
    reg_write(4'h8);
    chk("R4 ctrl", 32'(reg_rdata), 0);
    chk("R4 hv", 32'(hv_enable), 0);
    tick();
    chk("R4 no pulse", 32'(prog_cnt), 32'(pc));
    chk("R9 cleared on disarm", 32'(latches_loaded), 0);
    rd_check("R4 mem intact", 4'd5, exp_mem[5], 1'b0);

    // R2 capture and commit in the same cycle
    reg_write(4'h1);
    both_write(4'h9, 4'd3, 8'h3C);
    chk("R2 same cycle", 32'(reg_rdata), 32'h1);
    chk("R2 captured", 32'(latches_loaded), 1);

    // R10 program, R8 ignored reads
    reg_write(4'h9);
    chk("R2 commit", 32'(reg_rdata), 32'h9);
    chk("R10 hv", 32'(hv_enable), 1);
    rd_check("R8 ignored", 4'd7, 8'hFF, 1'b1);
    chk("R8 reg readable", 32'(reg_rdata), 32'h9);
    tick();
    chk("R10 one program", 32'(prog_cnt), 32'(pc + 1));
    chk("R10 no erase", 32'(erase_cnt), 0);
    exp_mem[3] = 8'h3C;

    // R3 frozen bits
    reg_write(4'hE);
    chk("R3 frozen", 32'(reg_rdata), 32'h9);
    reg_write(4'h6);
    chk("R3 only pe clears", 32'(reg_rdata), 32'h1);
    chk("R10 hv off", 32'(hv_enable), 0);
    for (int a = 0; a < NW; a++) rd_check("R6 programmed word", AW'(a), exp_mem[3], 1'b0);

    // R7 erase-select reads are normal
    reg_write(4'h3);
    chk("R9 kept", 32'(latches_loaded), 1);
    for (int a = 0; a < NW; a++) rd_check("R7", AW'(a), exp_mem[a], 1'b0);

    // R10 erase
    reg_write(4'hB);
    chk("R10 erase commit", 32'(reg_rdata), 32'hB);
    tick();
    chk("R10 one erase", 32'(erase_cnt), 1);
    chk("R10 erase not program", 32'(prog_cnt), 32'(pc + 1));
    reg_write(4'h3);
    for (int i = 0; i < NW; i++) exp_mem[i] = '1;
    for (int a = 0; a < NW; a++) rd_check("R10 erased", AW'(a), exp_mem[a], 1'b0);

    // R9 array write while disarmed
    reg_write(4'h0);
    arr_write(4'd2, 8'h55);
    chk("R9 disarmed write", 32'(latches_loaded), 0);
    rd_check("R9 mem untouched", 4'd2, exp_mem[2], 1'b0);

    // R11 reset during high voltage
    reg_write(4'h1);
    arr_write(4'd1, 8'h01);
    reg_write(4'h9);
    chk("R11 pre", 32'(hv_enable), 1);
    @(negedge clk); rst_n = 1'b0;
    #1;
    chk("R11 ctrl", 32'(reg_rdata), 0);
    chk("R11 hv", 32'(hv_enable), 0);
    chk("R11 loaded", 32'(latches_loaded), 0);
    chk("R11 pulse", 32'({mem_prog, mem_erase}), 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule